// File: doc/BRIEF.md
# Programmable Gain Sample Scaler

This block sits between an ADC input channel and a DAC output channel. It scales each 14-bit sample by a fixed-point gain and sends the result on. Both converters use sign-magnitude coding. The block turns each incoming sample into two's complement and multiplies it by an unsigned gain with eight fraction bits. It then shifts the product right with an arithmetic shift and clamps it to the symmetric 14-bit range. Last, it re-encodes the value for the DAC. The path runs as a three-stage pipeline, so one sample can enter on every clock.

The gain sits in the low bits of the first of four 32-bit control registers. These registers sit on a small word-addressed bus with a write strobe, a read strobe and a registered read acknowledge. Software writes the gain at run time and can read every register back. The width of the gain field is a parameter. With the default 8-bit field the largest gain is just under one. A 9-bit field allows gains up to about two, and then the clamp comes into play.

Top module: `scaled_loopback`

## Requirements
- R1: Input and output samples are 14 bits in sign-magnitude form. Bit 13 is the sign (1 = negative) and bits 12:0 are the magnitude. A positive value passes through with the same coding.
- R2: The output value is floor(v * g / 256). Here v is the input value and g is the unsigned gain taken from the low GAIN_W bits of the first control register. A gain of 128 halves the signal.
- R3: The gain is treated as a non-negative operand, so the sign of the result follows the input. The right shift rounds toward minus infinity, so -1 at gain 128 gives -1 and +1 at gain 128 gives 0.
- R4: Results above +8191 are clamped to +8191 (code 0x1FFF). Results below -8191 are clamped to -8191 (code 0x3FFF). Clamping can only happen when GAIN_W is larger than 8.
- R5: A zero result is always sent as 0x0000, never as negative zero (0x2000). This holds when the input is 0x2000 and when the gain is zero.
- R6: A sample presented before rising edge k appears on the output right after rising edge k+2 (three-cycle latency), and one sample is accepted every cycle.
- R7: Reset clears the output to 0x0000 and clears all four control registers to zero.
- R8: The four control registers are at word offsets 0x100, 0x101, 0x102 and 0x103. A write stores all 32 data bits, and a read returns the stored word.
- R9: The read acknowledge is high in exactly the cycle after a read strobe, with the read data valid in that cycle. A read of any other offset returns zero. A write to any other offset changes no register.
- R10: A gain write sampled at an edge applies from the sample captured at the next edge onward. The sample captured at the same edge as the write still uses the old gain.
- R11: Bits of the first register above the gain field have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_sample | input | DATA_W | Sign-magnitude sample from the ADC channel |
| dac_sample | output | DATA_W | Scaled sign-magnitude sample to the DAC channel |
| bus_addr | input | ADDR_W | Word offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Read acknowledge, one cycle after bus_rd |

## Verification
Every sample result is due on the output just after the third rising edge that follows the moment the sample is driven. The bench keeps a three-entry queue of model results and compares the oldest entry at the falling edge after each clock. Read data and the acknowledge are due after the first edge that follows the strobe, so the bench checks them at the falling edge of that same cycle. The gain model is updated only after the result for the sample driven with a write has been computed, which tests the rule on when a new gain takes effect.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned PROD_W = 32;
   typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/sgp_sm2tc.sv
// Sign-magnitude to two's complement; negative zero maps to zero.
module sgp_sm2tc #(
   parameter int DW = 14
) (
   input  logic [DW-1:0]        sm_in,
   output logic signed [DW-1:0] tc_out
);
   logic [DW-1:0] mag_ext;

   assign mag_ext = {1'b0, sm_in[DW-2:0]};
   assign tc_out  = sm_in[DW-1] ? -$signed(mag_ext) : $signed(mag_ext);
endmodule

// File: rtl/sgp_gain_mul.sv
// Signed sample times zero-extended unsigned gain, arithmetic right shift,
// truncated to the intermediate sum width.
module sgp_gain_mul #(
   parameter int DW    = 14,
   parameter int GW    = 8,
   parameter int FRAC  = 8,
   parameter int SUM_W = DW + 1
) (
   input  logic signed [DW-1:0]    tc_in,
   input  logic [GW-1:0]           gain,
   output logic signed [SUM_W-1:0] sum_out
);
   import sgp_pkg::*;

   logic signed [GW:0]         gain_s;
   logic signed [PROD_W-1:0]   prod;

   assign gain_s  = $signed({1'b0, gain});
   assign prod    = PROD_W'(gain_s) * PROD_W'(tc_in);
   assign sum_out = SUM_W'(prod >>> FRAC);
endmodule

// File: rtl/sgp_sat_tc2sm.sv
// Symmetric clamp to +/-(2^(DW-1)-1), then two's complement to sign-magnitude.
module sgp_sat_tc2sm #(
   parameter int DW    = 14,
   parameter int SUM_W = DW + 1
) (
   input  logic signed [SUM_W-1:0] sum_in,
   output logic [DW-1:0]           sm_out
);
   localparam int MAX_MAG = (2 ** (DW - 1)) - 1;
   localparam logic signed [SUM_W-1:0] HI_LIM = SUM_W'(MAX_MAG);
   localparam logic signed [SUM_W-1:0] LO_LIM = -HI_LIM;

   logic signed [SUM_W-1:0] clamped;
   logic                    neg;
   logic [DW-2:0]           mag;

   always_comb begin
      clamped = sum_in;
      if (sum_in > HI_LIM)
         clamped = HI_LIM;
      else if (sum_in < LO_LIM)
         clamped = LO_LIM;
   end

   assign neg    = clamped[SUM_W-1];
   assign mag    = (DW-1)'(neg ? -clamped : clamped);
   assign sm_out = {neg, mag};
endmodule

// File: rtl/sgp_regbank.sv
// Bank of word-addressed control registers with a registered read port.
module sgp_regbank #(
   parameter int AW   = 12,
   parameter int NREG = 4,
   parameter int BASE = 'h100
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           bus_addr,
   input  sgp_pkg::reg_word_t      bus_wdata,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   output sgp_pkg::reg_word_t      bus_rdata,
   output logic                    bus_ack,
   output sgp_pkg::reg_word_t      reg0
);
   import sgp_pkg::*;

   reg_word_t        regs [NREG];
   logic [NREG-1:0]  sel;
   reg_word_t        rd_mux;

   for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign sel[i] = (bus_addr == AW'(BASE + i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (bus_wr) begin
         for (int i = 0; i < NREG; i++)
            if (sel[i]) regs[i] <= bus_wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NREG; i++)
         if (sel[i]) rd_mux = regs[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack   <= bus_rd;
         bus_rdata <= bus_rd ? rd_mux : '0;
      end
   end

   assign reg0 = regs[0];
endmodule

// File: rtl/scaled_loopback.sv
// Three-stage gain path: capture/convert, multiply/shift, clamp/convert.
module scaled_loopback #(
   parameter int DATA_W   = 14,
   parameter int GAIN_W   = 8,
   parameter int FRAC_W   = 8,
   parameter int NUM_REGS = 4,
   parameter int ADDR_W   = 12,
   parameter int REG_BASE = 'h100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    adc_sample,
   output logic [DATA_W-1:0]    dac_sample,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   output logic [31:0]          bus_rdata,
   output logic                 bus_ack
);
   import sgp_pkg::*;

   localparam int SUM_W = DATA_W + 1;
   localparam longint MAX_SHIFTED =
      (((longint'(1) << GAIN_W) - 1) * ((longint'(1) << (DATA_W - 1)) - 1)) >>> FRAC_W;
   localparam longint SUM_LIM = (longint'(1) << DATA_W) - 1;

   if (GAIN_W < 1 || GAIN_W > int'(REG_W)) begin : g_bad_gain
      $error("GAIN_W must lie in 1..32");
   end
   if (DATA_W < 2 || DATA_W + GAIN_W + 1 > int'(PROD_W)) begin : g_bad_data
      $error("DATA_W out of range for the product width");
   end
   if (MAX_SHIFTED > SUM_LIM) begin : g_bad_sum
      $error("shifted product can exceed the intermediate sum width");
   end
   if (NUM_REGS < 1 || REG_BASE + NUM_REGS > (1 << ADDR_W)) begin : g_bad_map
      $error("register window does not fit the address width");
   end

   reg_word_t                 reg0;
   logic signed [DATA_W-1:0]  tc_in;
   logic signed [DATA_W-1:0]  s1_tc;
   logic [GAIN_W-1:0]         s1_gain;
   logic signed [SUM_W-1:0]   mul_sum;
   logic signed [SUM_W-1:0]   s2_sum;
   logic [DATA_W-1:0]         sm_res;

   sgp_regbank #(
      .AW   (ADDR_W),
      .NREG (NUM_REGS),
      .BASE (REG_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .bus_ack   (bus_ack),
      .reg0      (reg0)
   );

   sgp_sm2tc #(.DW(DATA_W)) u_in_conv (
      .sm_in  (adc_sample),
      .tc_out (tc_in)
   );

   sgp_gain_mul #(
      .DW    (DATA_W),
      .GW    (GAIN_W),
      .FRAC  (FRAC_W),
      .SUM_W (SUM_W)
   ) u_mul (
      .tc_in   (s1_tc),
      .gain    (s1_gain),
      .sum_out (mul_sum)
   );

   sgp_sat_tc2sm #(
      .DW    (DATA_W),
      .SUM_W (SUM_W)
   ) u_out_conv (
      .sum_in (s2_sum),
      .sm_out (sm_res)
   );

   // gain is captured alongside the sample so a write lands on the next sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_tc      <= '0;
         s1_gain    <= '0;
         s2_sum     <= '0;
         dac_sample <= '0;
      end else begin
         s1_tc      <= tc_in;
         s1_gain    <= reg0[GAIN_W-1:0];
         s2_sum     <= mul_sum;
         dac_sample <= sm_res;
      end
   end
endmodule

// File: rtl/scaled_loopback_chk.sv
module scaled_loopback_chk #(
   parameter int DW   = 14,
   parameter int AW   = 12,
   parameter int NREG = 4,
   parameter int BASE = 'h100
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] adc_sample,
   input logic [DW-1:0] dac_sample,
   input logic [AW-1:0] bus_addr,
   input logic          bus_rd,
   input logic [31:0]   bus_rdata,
   input logic          bus_ack
);
   logic in_window;
   assign in_window = (bus_addr >= AW'(BASE)) && (bus_addr < AW'(BASE + NREG));

   assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_n |=> dac_sample == '0);

   assert_no_neg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sample != {1'b1, {(DW-1){1'b0}}});

   assert_sign_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sample[DW-1] |-> $past(adc_sample[DW-1], 3));

   assert_zero_in_zero_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adc_sample[DW-2:0], 3) == '0) |-> dac_sample == '0);

   assert_ack_follows_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_ack);

   assert_no_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_ack);

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !in_window) |=> bus_rdata == '0);
endmodule

bind scaled_loopback scaled_loopback_chk #(
   .DW   (DATA_W),
   .AW   (ADDR_W),
   .NREG (NUM_REGS),
   .BASE (REG_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .adc_sample (adc_sample),
   .dac_sample (dac_sample),
   .bus_addr   (bus_addr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .bus_ack    (bus_ack)
);

// File: tb/scaled_loopback_tb.sv
module scaled_loopback_tb;
   localparam int AW   = 12;
   localparam int BASE = 'h100;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic [13:0]   adc;
   logic [AW-1:0] addr;
   logic [31:0]   wdata;
   logic          wr, rd;
   logic [13:0]   dac_n, dac_w;
   logic [31:0]   rdata_n, rdata_w;
   logic          ack_n, ack_w;

   scaled_loopback u_dut (
      .clk(clk), .rst_n(rst_n), .adc_sample(adc), .dac_sample(dac_n),
      .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd),
      .bus_rdata(rdata_n), .bus_ack(ack_n));

   scaled_loopback #(.GAIN_W(9)) u_dut_wide (
      .clk(clk), .rst_n(rst_n), .adc_sample(adc), .dac_sample(dac_w),
      .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd),
      .bus_rdata(rdata_w), .bus_ack(ack_w));

   int errors = 0;
   int checks = 0;
   logic [31:0] regs_m [4];
   logic [13:0] exp_n [3];
   logic [13:0] exp_w [3];
   int filled = 0;

   function automatic logic [13:0] model(logic [13:0] a, int unsigned g);
      longint v, p;
      v = longint'(a[12:0]);
      if (a[13]) v = -v;
      p = v * longint'(g);
      p = p >>> 8;
      if (p > 8191) p = 8191;
      if (p < -8191) p = -8191;
      if (p < 0) return {1'b1, 13'(-p)};
      return {1'b0, 13'(p)};
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic cyc(input logic [13:0] a, input logic w, input logic r,
                      input logic [AW-1:0] ad, input logic [31:0] d, input string tag);
      logic [13:0] en, ew;
      logic [31:0] rexp;
      int idx;
      adc = a; wr = w; rd = r; addr = ad; wdata = d;
      en = model(a, int'(regs_m[0][7:0]));
      ew = model(a, int'(regs_m[0][8:0]));
      idx = int'(ad) - BASE;
      rexp = 32'h0;
      if (r && idx >= 0 && idx < 4) rexp = regs_m[idx];
      @(posedge clk);
      if (w && idx >= 0 && idx < 4) regs_m[idx] = d;
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      exp_n[2] = exp_n[1]; exp_n[1] = exp_n[0]; exp_n[0] = en;
      exp_w[2] = exp_w[1]; exp_w[1] = exp_w[0]; exp_w[0] = ew;
      filled++;
      if (filled >= 3) begin
         chk(tag, "dac", 32'(dac_n), 32'(exp_n[2]));
         chk(tag, "dac wide gain", 32'(dac_w), 32'(exp_w[2]));
      end
      chk("R9", "ack", 32'(ack_n), 32'(r));
      if (r) begin
         chk(tag, "rdata", rdata_n, rexp);
         chk(tag, "rdata wide", rdata_w, rexp);
      end
   endtask

   task automatic sample(input logic [13:0] a, input string tag);
      cyc(a, 1'b0, 1'b0, '0, '0, tag);
   endtask

   task automatic wreg(input int off, input logic [31:0] d, input string tag);
      cyc(14'h0, 1'b1, 1'b0, AW'(BASE + off), d, tag);
   endtask

   task automatic rreg(input logic [AW-1:0] ad, input string tag);
      cyc(14'h0, 1'b0, 1'b1, ad, '0, tag);
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(4 * 50000);
      errors++; checks++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      void'($urandom(32'd24681));
      for (int i = 0; i < 4; i++) regs_m[i] = '0;
      for (int i = 0; i < 3; i++) begin exp_n[i] = '0; exp_w[i] = '0; end
      rst_n = 1'b0; adc = 14'h1ABC; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      chk("R7", "dac in reset", 32'(dac_n), 32'h0);
      chk("R7", "dac wide in reset", 32'(dac_w), 32'h0);
      rst_n = 1'b1;

      // R7: registers come out of reset cleared
      for (int i = 0; i < 4; i++) rreg(AW'(BASE + i), "R7");
      sample(14'h1FFF, "R7");
      sample(14'h3FFF, "R7");
      sample(14'h0, "R7");

      // R2 / R3 / R1 / R5 at gain 0.5
      wreg(0, 32'h80, "R8");
      sample(14'd100, "R2");
      sample(14'h2000 | 14'd100, "R3");
      sample(14'h2001, "R3");
      sample(14'h0001, "R3");
      sample(14'h2000, "R5");
      sample(14'h1FFF, "R1");
      sample(14'h0, "R6");
      sample(14'h0, "R6");
      sample(14'd512, "R6");
      sample(14'h0, "R6");
      sample(14'h0, "R6");

      // R5: gain zero with negative inputs
      wreg(0, 32'h0, "R8");
      sample(14'h3FFF, "R5");
      sample(14'h2123, "R5");
      sample(14'h0, "R5");

      // R4: largest gains, wide instance saturates
      wreg(0, 32'h1FF, "R4");
      sample(14'h1FFF, "R4");
      sample(14'h3FFF, "R4");
      sample(14'h1000, "R4");
      sample(14'h3000, "R4");
      sample(14'h0, "R4");

      // R11: upper bits of the first register ignored
      wreg(0, 32'hABCDE140, "R11");
      sample(14'h1FFF, "R11");
      sample(14'h2800, "R11");
      rreg(AW'(BASE), "R11");

      // R10: write lands between back-to-back samples
      sample(14'h0FFF, "R10");
      cyc(14'h0FFF, 1'b1, 1'b0, AW'(BASE), 32'h40, "R10");
      sample(14'h0FFF, "R10");
      cyc(14'h2FFF, 1'b1, 1'b0, AW'(BASE), 32'hFF, "R10");
      sample(14'h2FFF, "R10");
      sample(14'h0, "R10");

      // R8: full-width write and read back of every register
      wreg(1, 32'hDEADBEEF, "R8");
      wreg(2, 32'h12345678, "R8");
      wreg(3, 32'hFFFFFFFF, "R8");
      for (int i = 0; i < 4; i++) rreg(AW'(BASE + i), "R8");

      // R9: unmapped reads return zero, unmapped writes change nothing
      rreg(AW'(BASE - 1), "R9");
      rreg(AW'(BASE + 4), "R9");
      rreg(AW'(0), "R9");
      rreg(AW'(12'hFFF), "R9");
      cyc(14'h0, 1'b1, 1'b0, AW'(BASE + 4), 32'h5A5A5A5A, "R9");
      cyc(14'h0, 1'b1, 1'b0, AW'(BASE - 1), 32'hA5A5A5A5, "R9");
      rreg(AW'(BASE + 4), "R9");
      rreg(AW'(BASE - 1), "R9");
      for (int i = 0; i < 4; i++) rreg(AW'(BASE + i), "R9");

      // random traffic
      for (int n = 0; n < 400; n++) begin
         int unsigned pick;
         pick = $urandom % 16;
         if (pick == 0)
            cyc(14'($urandom), 1'b1, 1'b0, AW'(BASE), $urandom, "R2");
         else if (pick == 1)
            cyc(14'($urandom), 1'b0, 1'b1, AW'(BASE + ($urandom % 6)), '0, "R8");
         else
            sample(14'($urandom), "R2");
      end
      repeat (3) sample(14'h0, "R6");
      summary();
   end
endmodule